// File: doc/BRIEF.md
# Transmit Descriptor Fetch Controller

This block decides when a transmit DMA engine reads the next buffer descriptor from a single descriptor ring. In poll mode, a not-ready descriptor is read again after a fixed number of serial-clock enables spent idle. Software can also pulse an on-demand strobe, which starts a read at once and restarts the poll interval. In wait mode nothing is polled. Descriptors are read back to back until the same not-ready descriptor has been seen three times in a row. The controller then parks in a halt state, which only a software clear ends.

A graceful stop lets any descriptor read already in flight finish. It then waits for the transmit FIFO to empty and for no frame to remain scheduled, and only then pulses a stop-complete event. If nothing is pending, the event comes at once. Dropping the stop request resumes polling with a fresh interval.

A second path gates frame events such as buffer done, frame done, errors, underrun, late collision and retry limit. With write-with-response enabled, these events are collected until the memory system acknowledges the descriptor write-back, and they are then released together. With it disabled, they pass through after one register stage.

Top module: `txbd_fetch_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `fetch_req`, `halted`, `stop_done` and `evt_out` are all low. The poll interval starts from zero at release.
- R2: In poll mode (`wait_mode`=0) with `sclk_en` held high, the first read request rises POLL_CYCLES clocks after reset release. After a not-ready read, the next request rises POLL_CYCLES+2 clocks after the previous one. The interval advances only on cycles with `sclk_en` high.
- R3: A one-cycle `fetch_now` pulse while idle, with `wait_mode`=0, `single_ring`=1 and `gstop`=0, raises `fetch_req` on the next cycle and restarts the poll interval. With `single_ring`=0, or while halted in wait mode, the pulse starts no read and leaves the interval unchanged.
- R4: `fetch_req` stays high until `fetch_done`, which carries the descriptor's ready bit on `bd_ready`. A ready descriptor is followed by the next request two clocks after the previous one rose.
- R5: In wait mode, reads run back to back with no polling. After the third consecutive not-ready read, `halted` rises and stays high until `halt_clr`. No further read starts, and neither `stop_done` nor `evt_out` fires.
- R6: A ready read clears the not-ready count, and so does `halt_clr`. After `halt_clr`, reads resume, and the halt needs three fresh consecutive not-ready reads.
- R7: Raising `gstop` while idle with `fifo_empty`=1 and `tx_busy`=0 makes `stop_done` high for exactly the next cycle.
- R8: With `gstop` high, no new read request starts. While `fifo_empty`=0 or `tx_busy`=1, `stop_done` stays low. It pulses for one cycle on the cycle after both conditions clear.
- R9: A read request already pending when `gstop` rises stays high until `fetch_done`. `stop_done` pulses two cycles after that handshake.
- R10: Dropping `gstop` after the stop completes restarts polling. The next request rises POLL_CYCLES+1 clocks after `gstop` falls.
- R11: With `wwr_en`=0, each `evt_in` bit set in a cycle appears on `evt_out` in the following cycle, for one cycle.
- R12: With `wwr_en`=1, `evt_out` stays zero until `wb_ack`. The cycle after `wb_ack`, it shows the OR of every event collected since the last release, including events that arrive in the `wb_ack` cycle. It returns to zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_en | input | 1 | Serial-clock enable that advances the poll interval |
| wait_mode | input | 1 | 1 selects wait mode, 0 selects poll mode |
| single_ring | input | 1 | 1 when single-ring scheduling is configured |
| fetch_now | input | 1 | On-demand read strobe, one cycle per write |
| gstop | input | 1 | Graceful stop request, level |
| halt_clr | input | 1 | Software clear of the halt status, one-cycle pulse |
| fifo_empty | input | 1 | Transmit FIFO holds no data |
| tx_busy | input | 1 | One or more frames are still scheduled |
| fetch_done | input | 1 | Descriptor read completed |
| bd_ready | input | 1 | Ready bit of the descriptor, valid with fetch_done |
| fetch_req | output | 1 | Descriptor read request |
| halted | output | 1 | Halt status in wait mode |
| stop_done | output | 1 | Graceful-stop completion pulse |
| wwr_en | input | 1 | Enables holding events until write-back acknowledge |
| evt_in | input | NEV | Raw frame events, one bit per kind |
| wb_ack | input | 1 | Descriptor write-back acknowledge |
| evt_out | output | NEV | Gated frame events |

## Verification
A wrong state register shows up as a missing or extra `fetch_req` edge within two clocks, or as `stop_done` firing while the FIFO still holds data. A poll counter that is off by one shows as a request edge one clock early or late against the POLL_CYCLES interval, so request spacing is measured to the exact clock. A not-ready count that fails to clear shows as `halted` rising after too few reads in a mixed ready and not-ready sequence. A bad event holding register shows as events leaking before the acknowledge, or as bits lost in the merged release on the cycle after `wb_ack`.

// File: rtl/txbd_fetch_ctrl.sv
module txbd_fetch_ctrl #(
  parameter int POLL_CYCLES = 512,
  parameter int RETRIES     = 2,
  parameter int NEV         = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_en,
  input  logic           wait_mode,
  input  logic           single_ring,
  input  logic           fetch_now,
  input  logic           gstop,
  input  logic           halt_clr,
  input  logic           fifo_empty,
  input  logic           tx_busy,
  input  logic           fetch_done,
  input  logic           bd_ready,
  output logic           fetch_req,
  output logic           halted,
  output logic           stop_done,
  input  logic           wwr_en,
  input  logic [NEV-1:0] evt_in,
  input  logic           wb_ack,
  output logic [NEV-1:0] evt_out
);

  localparam int TW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam int RW = $clog2(RETRIES + 2);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EVAL, S_HALT, S_DRAIN, S_STOP} st_t;

  st_t            st, st_n;
  logic [TW-1:0]  tmr;
  logic [RW-1:0]  miss;
  logic           rdy_q;
  logic [NEV-1:0] pend;

  wire drained  = fifo_empty && !tx_busy;
  wire poll_hit = sclk_en && (tmr == TW'(POLL_CYCLES - 1));
  wire demand   = fetch_now && single_ring && !wait_mode;
  wire miss_max = (miss == RW'(RETRIES));
  wire tmr_hold = (st != S_IDLE) || wait_mode || gstop;
  wire [NEV-1:0] pend_n = pend | evt_in;
  wire release_ev = !wwr_en || wb_ack;

  assign fetch_req = (st == S_FETCH);
  assign halted    = (st == S_HALT);

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE:
        if (gstop)                               st_n = drained ? S_STOP : S_DRAIN;
        else if (wait_mode || demand || poll_hit) st_n = S_FETCH;
      S_FETCH:
        if (fetch_done) st_n = S_EVAL;
      S_EVAL:
        if (gstop)          st_n = drained ? S_STOP : S_DRAIN;
        else if (rdy_q)     st_n = S_FETCH;
        else if (wait_mode) st_n = miss_max ? S_HALT : S_FETCH;
        else                st_n = S_IDLE;
      S_HALT:
        if (halt_clr) st_n = S_IDLE;
      S_DRAIN:
        if (drained) st_n = S_STOP;
      S_STOP:
        if (!gstop) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      miss      <= '0;
      rdy_q     <= 1'b0;
      stop_done <= 1'b0;
      pend      <= '0;
      evt_out   <= '0;
    end else begin
      st        <= st_n;
      stop_done <= (st_n == S_STOP) && (st != S_STOP);

      if (tmr_hold)     tmr <= '0;
      else if (sclk_en) tmr <= poll_hit ? '0 : tmr + 1'b1;

      if (st == S_FETCH && fetch_done) rdy_q <= bd_ready;

      if (st == S_HALT && halt_clr)
        miss <= '0;
      else if (st == S_EVAL) begin
        if (rdy_q)                       miss <= '0;
        else if (wait_mode && !miss_max) miss <= miss + 1'b1;
      end

      if (release_ev) begin
        evt_out <= pend_n;
        pend    <= '0;
      end else begin
        evt_out <= '0;
        pend    <= pend_n;
      end
    end
  end

endmodule

// File: rtl/txbd_fetch_ctrl_chk.sv
module txbd_fetch_ctrl_chk #(
  parameter int NEV = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           gstop,
  input logic           halt_clr,
  input logic           fifo_empty,
  input logic           tx_busy,
  input logic           fetch_done,
  input logic           fetch_req,
  input logic           halted,
  input logic           stop_done,
  input logic           wwr_en,
  input logic [NEV-1:0] evt_in,
  input logic           wb_ack,
  input logic [NEV-1:0] evt_out
);

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_done |=> fetch_req);

  a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !halt_clr |=> halted);

  a_r8_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !stop_done);

  a_r8_stop_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |-> $past(fifo_empty && !tx_busy));

  a_r9_no_new_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    gstop && !fetch_req |=> !fetch_req);

  a_r11_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !wwr_en && (evt_in != '0) |=> ((evt_out & $past(evt_in)) == $past(evt_in)));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wwr_en && !wb_ack |=> (evt_out == '0));

endmodule

bind txbd_fetch_ctrl txbd_fetch_ctrl_chk #(.NEV(NEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .gstop(gstop), .halt_clr(halt_clr),
  .fifo_empty(fifo_empty), .tx_busy(tx_busy), .fetch_done(fetch_done),
  .fetch_req(fetch_req), .halted(halted), .stop_done(stop_done),
  .wwr_en(wwr_en), .evt_in(evt_in), .wb_ack(wb_ack), .evt_out(evt_out)
);

// File: tb/tb_txbd_fetch_ctrl.sv
module tb_txbd_fetch_ctrl;
  localparam int P   = 512;
  localparam int NEV = 6;
  localparam int K_HALT = 1, K_STOP = 2, K_EVT = 3;

  logic clk = 0, rst_n = 0;
  logic sclk_en = 0, wait_mode = 0, single_ring = 1, fetch_now = 0, gstop = 0;
  logic halt_clr = 0, fifo_empty = 1, tx_busy = 0, fetch_done = 0, bd_ready = 0;
  logic wwr_en = 0, wb_ack = 0;
  logic [NEV-1:0] evt_in = '0;
  logic fetch_req, halted, stop_done;
  logic [NEV-1:0] evt_out;

  txbd_fetch_ctrl #(.POLL_CYCLES(P), .RETRIES(2), .NEV(NEV)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .wait_mode(wait_mode),
    .single_ring(single_ring), .fetch_now(fetch_now), .gstop(gstop),
    .halt_clr(halt_clr), .fifo_empty(fifo_empty), .tx_busy(tx_busy),
    .fetch_done(fetch_done), .bd_ready(bd_ready), .fetch_req(fetch_req),
    .halted(halted), .stop_done(stop_done), .wwr_en(wwr_en), .evt_in(evt_in),
    .wb_ack(wb_ack), .evt_out(evt_out)
  );

  always #10 clk = ~clk;

  typedef struct { int kind; int data; string req; } item_t;
  item_t expq[$];
  int    rq[$];
  int    total = 0, bad = 0;
  int    cyc = 0, nfetch = 0, nstop = 0, last_rise = 0;
  logic  prev_req = 0, prev_halt = 0, hold = 0, dflt_ready = 0;

  always @(posedge clk) cyc++;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic push_exp(int k, int d, string req);
    item_t it;
    it.kind = k; it.data = d; it.req = req;
    expq.push_back(it);
  endtask

  task automatic observe(int k, int d);
    item_t it;
    total++;
    if (expq.size() == 0) begin
      bad++;
      $display("FAIL %s unexpected act=kind%0d/%0d exp=none",
               k == K_HALT ? "R5" : (k == K_STOP ? "R8" : "R12"), k, d);
    end else begin
      it = expq.pop_front();
      if (it.kind != k || it.data != d) begin
        bad++;
        $display("FAIL %s act=kind%0d/%0d exp=kind%0d/%0d", it.req, k, d, it.kind, it.data);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (fetch_req && !prev_req) begin nfetch++; last_rise = cyc; end
      if (halted && !prev_halt) observe(K_HALT, 0);
      if (stop_done) begin nstop++; observe(K_STOP, 0); end
      if (evt_out != '0) observe(K_EVT, int'(evt_out));
    end
    prev_req  = fetch_req;
    prev_halt = halted;
  end

  // descriptor memory responder
  always @(negedge clk) begin
    if (!rst_n || fetch_done) fetch_done = 0;
    else if (fetch_req && !hold) begin
      fetch_done = 1;
      bd_ready   = (rq.size() > 0) ? rq.pop_front()[0] : dflt_ready;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic do_reset(logic wm, logic se);
    tick();
    rst_n = 0; wait_mode = wm; sclk_en = se; gstop = 0; fetch_now = 0;
    halt_clr = 0; fifo_empty = 1; tx_busy = 0; wwr_en = 0; wb_ack = 0;
    evt_in = '0; hold = 0; dflt_ready = 0; single_ring = 1;
    tick(3);
    rst_n = 1;
  endtask

  task automatic wait_fetch(int n, string req);
    int k = 0;
    while (nfetch < n && k < 3000) begin tick(); k++; end
    if (nfetch < n) chk(req, nfetch, n);
  endtask

  task automatic pulse_demand();
    fetch_now = 1; tick(); fetch_now = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0, r, d0;

    // R1 reset state
    rst_n = 0; sclk_en = 1;
    tick(3);
    chk("R1 req in reset", fetch_req, 0);
    chk("R1 halted in reset", halted, 0);
    chk("R1 stop in reset", stop_done, 0);
    chk("R1 evt in reset", evt_out, 0);

    // R2 polling cadence
    do_reset(0, 1);
    r = cyc; n0 = nfetch;
    tick();
    chk("R1 req after release", fetch_req, 0);
    wait_fetch(n0 + 1, "R2 first poll");
    chk("R2 first poll delay", last_rise - r, P);
    d0 = last_rise;
    wait_fetch(n0 + 2, "R2 second poll");
    chk("R2 poll interval", last_rise - d0, P + 2);

    // R3 on-demand restarts the interval
    tick(100);
    n0 = nfetch;
    pulse_demand();
    chk("R3 demand req", fetch_req, 1);
    chk("R3 demand count", nfetch, n0 + 1);
    d0 = last_rise;
    wait_fetch(n0 + 2, "R3 poll after demand");
    chk("R3 timer restarted", last_rise - d0, P + 2);

    // R3 ignored without single-ring scheduling
    d0 = last_rise; n0 = nfetch;
    single_ring = 0;
    tick(10);
    pulse_demand();
    tick(5);
    chk("R3 ignored no fetch", nfetch, n0);
    single_ring = 1;
    wait_fetch(n0 + 1, "R3 ignored poll");
    chk("R3 ignored timer kept", last_rise - d0, P + 2);

    // R2 no enable, no polling
    sclk_en = 0;
    n0 = nfetch;
    tick(1200);
    chk("R2 no sclk_en no poll", nfetch, n0);

    // R4 held request and ready follow-on
    hold = 1;
    pulse_demand();
    tick(30);
    chk("R4 req held", fetch_req, 1);
    n0 = nfetch;
    rq.push_back(1); rq.push_back(1); rq.push_back(0);
    hold = 0;
    wait_fetch(n0 + 1, "R4 next fetch");
    d0 = last_rise;
    wait_fetch(n0 + 2, "R4 third fetch");
    chk("R4 ready follow-on gap", last_rise - d0, 2);
    tick(10);
    chk("R4 not-ready ends burst", nfetch, n0 + 2);

    // R5 wait mode halts after three not-ready reads
    do_reset(1, 1);
    n0 = nfetch;
    push_exp(K_HALT, 0, "R5");
    tick(40);
    chk("R5 reads before halt", nfetch - n0, 3);
    chk("R5 halted", halted, 1);
    tick(600);
    chk("R5 no polling when halted", nfetch - n0, 3);
    pulse_demand();
    tick(5);
    chk("R3 demand ignored in wait", nfetch - n0, 3);
    chk("R5 still halted", halted, 1);

    // R6 counter clears on ready and on halt_clr
    push_exp(K_HALT, 0, "R6");
    rq.push_back(0); rq.push_back(1);
    halt_clr = 1; tick(); halt_clr = 0;
    chk("R6 halt cleared", halted, 0);
    tick(60);
    chk("R6 reads after clear", nfetch - n0, 8);
    chk("R6 halted again", halted, 1);

    // R7 immediate stop, R8 no fetch while stopped, R10 restart
    do_reset(0, 1);
    tick(20);
    n0 = nfetch; r = nstop;
    push_exp(K_STOP, 0, "R7");
    gstop = 1;
    tick();
    chk("R7 stop at once", stop_done, 1);
    tick();
    chk("R7 stop one cycle", stop_done, 0);
    tick(700);
    chk("R8 no fetch while stopped", nfetch, n0);
    chk("R7 single stop event", nstop - r, 1);
    gstop = 0;
    d0 = cyc;
    wait_fetch(n0 + 1, "R10 restart");
    chk("R10 restart interval", last_rise - d0, P + 1);

    // R8 drain waits for FIFO and schedule
    sclk_en = 0;
    tick(5);
    r = nstop;
    fifo_empty = 0; tx_busy = 1; gstop = 1;
    tick(50);
    chk("R8 waits for FIFO", nstop, r);
    fifo_empty = 1;
    tick(10);
    chk("R8 waits for schedule", nstop, r);
    push_exp(K_STOP, 0, "R8");
    tx_busy = 0;
    tick();
    chk("R8 stop after drain", stop_done, 1);
    tick();
    gstop = 0;
    tick(3);

    // R9 in-flight read finishes before stop
    hold = 1;
    pulse_demand();
    chk("R9 read pending", fetch_req, 1);
    r = nstop;
    gstop = 1;
    tick(20);
    chk("R9 req kept", fetch_req, 1);
    chk("R9 no early stop", nstop, r);
    push_exp(K_STOP, 0, "R9");
    hold = 0;
    tick(5);
    chk("R9 stop after read", nstop, r + 1);
    chk("R9 req dropped", fetch_req, 0);
    gstop = 0;
    tick(3);

    // R11 pass-through events
    push_exp(K_EVT, 5, "R11");
    evt_in = 6'b000101;
    tick();
    evt_in = '0;
    chk("R11 event passes", evt_out, 5);
    tick();
    chk("R11 one cycle", evt_out, 0);

    // R12 held until write-back ack
    wwr_en = 1;
    evt_in = 6'b000010; tick(); evt_in = '0;
    tick(5);
    evt_in = 6'b100000; tick(); evt_in = '0;
    tick(5);
    chk("R12 held", evt_out, 0);
    push_exp(K_EVT, 6'b110010, "R12");
    evt_in = 6'b010000; wb_ack = 1;
    tick();
    evt_in = '0; wb_ack = 0;
    chk("R12 merged release", evt_out, 6'b110010);
    tick();
    chk("R12 release one cycle", evt_out, 0);

    tick(5);
    chk("R12 scoreboard drained", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule